// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker with Colour Palette

This block sits between a framebuffer word stream and a display timing generator. It takes 32-bit memory words from a valid/ready stream and, for each pixel request from the timing generator, returns one 24-bit RGB value one clock later. A two-bit format input chooses how a word is cut into pixels. In the indexed mode a word holds four 8-bit palette indices. In the 16-bit mode a word holds two 5-6-5 pixels, which are widened to 8 bits per channel. In the direct mode each word carries one pixel.

The colour palette has 256 entries. It is loaded by single 32-bit register writes that carry the entry index and all three colour channels together. When the timing generator asks for a pixel and no word is ready, the block outputs black and flags an underflow for that pixel.

Top module: `pix_unpack`

## Requirements
- R1: After reset, `pix_valid` and `underflow` are 0, and `word_ready` is 0 while `pix_req` is low.
- R2: A `pix_req` cycle with a non-zero format gives `pix_valid` high on the next cycle. `pix_valid` is low after any other cycle.
- R3: Format code 3 takes one pixel per word, with red from bits 23:16, green from 15:8 and blue from 7:0. Bits 31:24 have no effect on the output.
- R4: Format code 2 takes two pixels per word, starting with bits 31:16 and then bits 15:0. In each halfword, red is bits 15:11, green is 10:5 and blue is 4:0. Each channel is widened to 8 bits by copying its top bits into the empty low bits.
- R5: Format code 1 takes four 8-bit indices per word, starting with bits 31:24 and moving down. Each pixel is the palette entry at that index.
- R6: When `pal_we` is high, the palette entry at `pal_wdata[31:24]` is loaded with red `pal_wdata[23:16]`, green `pal_wdata[15:8]` and blue `pal_wdata[7:0]`.
- R7: If a palette write and a palette lookup hit the same index in the same cycle, the lookup returns the value held before the write. Later lookups return the new value.
- R8: If a pixel is requested with no partly used word held and `word_valid` low, the next cycle shows `pix_valid`=1, `pix_rgb`=0 and `underflow`=1. No word is consumed.
- R9: `word_ready` is high only in a `pix_req` cycle with a non-zero format and no partly used word held. A word is consumed when `word_valid` and `word_ready` are both high.
- R10: Format code 0 turns output off. Pixel requests are ignored, no word is consumed and `pix_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt | input | 2 | Pixel format: 0 off, 1 indexed 8-bit, 2 RGB 5-6-5, 3 direct 24-bit |
| pal_we | input | 1 | Palette write strobe |
| pal_wdata | input | 32 | Palette write: index, red, green, blue |
| word_valid | input | 1 | Framebuffer word available |
| word_data | input | 32 | Framebuffer word |
| word_ready | output | 1 | Block takes the word this cycle |
| pix_req | input | 1 | Pixel request from the timing generator |
| pix_valid | output | 1 | Pixel output valid |
| pix_rgb | output | 24 | Pixel colour, red in 23:16, green 15:8, blue 7:0 |
| underflow | output | 1 | Pixel was requested with no data available |

## Verification
The bench checks the order of pixels inside a word. A design that reversed this order would show the low byte or low halfword first, and the vector pixels would not match. It uses 5-6-5 values with the top channel bits set and cleared. This catches a design that pads with zeros instead of copying bits, because it would give 0xF8 rather than 0xFF for full red. It writes a palette entry in the same cycle that the entry is looked up, which catches a write-first memory that returns the new colour too early. It also requests pixels with no word present and with the format off. The first exposes a design that takes a stale word or shows leftover colour. The second exposes one that takes words or raises `pix_valid` when it should not.

// File: rtl/pu_pkg.sv
`timescale 1ns/1ps
package pu_pkg;
  typedef enum logic [1:0] {
    FMT_OFF   = 2'd0,
    FMT_IDX8  = 2'd1,
    FMT_RGB16 = 2'd2,
    FMT_RGB32 = 2'd3
  } pix_fmt_e;

  // number of pixels packed in one 32-bit word for a format
  function automatic logic [2:0] slots_of(input pix_fmt_e f);
    case (f)
      FMT_IDX8:  return 3'd4;
      FMT_RGB16: return 3'd2;
      default:   return 3'd1;
    endcase
  endfunction

  // byte at slot s, most significant first
  function automatic logic [7:0] byte_at(input logic [31:0] w, input logic [1:0] s);
    return w[31 - 8*s -: 8];
  endfunction

  // halfword at slot s, most significant first
  function automatic logic [15:0] half_at(input logic [31:0] w, input logic s);
    return s ? w[15:0] : w[31:16];
  endfunction

  // 5-6-5 to 8-8-8 with top-bit replication
  function automatic logic [23:0] widen565(input logic [15:0] h);
    logic [4:0] r5;
    logic [5:0] g6;
    logic [4:0] b5;
    r5 = h[15:11];
    g6 = h[10:5];
    b5 = h[4:0];
    return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
  endfunction
endpackage

// File: rtl/pu_palette.sv
`timescale 1ns/1ps
module pu_palette #(
  parameter int IDX_W = 8,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [RGB_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [RGB_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [RGB_W-1:0] mem [DEPTH];

  // read and write in one process: a read in the write cycle sees old data
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/pu_word_buf.sv
`timescale 1ns/1ps
module pu_word_buf #(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_active,
  input  logic [SLOT_W:0]   slots,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              avail,
  output logic              have_word,
  output logic              consume,
  output logic [WORD_W-1:0] cur_word,
  output logic [SLOT_W-1:0] cur_slot
);
  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic              held_q;
  logic              last_slot;

  assign have_word = held_q;
  assign in_ready  = req_active && !held_q;
  assign avail     = held_q || in_valid;
  assign consume   = req_active && avail;
  assign cur_word  = held_q ? word_q : in_data;
  assign cur_slot  = held_q ? slot_q : '0;
  assign last_slot = ({1'b0, cur_slot} + 1'b1) >= slots;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
    end else if (consume) begin
      if (last_slot) begin
        held_q <= 1'b0;
        slot_q <= '0;
      end else begin
        held_q <= 1'b1;
        word_q <= cur_word;
        slot_q <= cur_slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pu_fmt_expand.sv
`timescale 1ns/1ps
module pu_fmt_expand
  import pu_pkg::*;
(
  input  pix_fmt_e    fmt,
  input  logic [31:0] word,
  input  logic [1:0]  slot,
  output logic [23:0] direct_rgb,
  output logic [7:0]  pal_idx
);
  always_comb begin
    pal_idx = byte_at(word, slot);
    case (fmt)
      FMT_RGB16: direct_rgb = widen565(half_at(word, slot[0]));
      FMT_RGB32: direct_rgb = word[23:0];
      default:   direct_rgb = '0;
    endcase
  end
endmodule

// File: rtl/pix_unpack.sv
`timescale 1ns/1ps
module pix_unpack
  import pu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8,
  parameter int CH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt,
  input  logic              pal_we,
  input  logic [31:0]       pal_wdata,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              pix_req,
  output logic              pix_valid,
  output logic [3*CH_W-1:0] pix_rgb,
  output logic              underflow
);
  localparam int RGB_W  = 3 * CH_W;
  localparam int SLOT_W = 2;

  pix_fmt_e          fmt_e;
  logic              req_active;
  logic              avail, have_word, consume;
  logic [WORD_W-1:0] cur_word;
  logic [SLOT_W-1:0] cur_slot;
  logic [RGB_W-1:0]  direct_rgb, pal_rdata;
  logic [IDX_W-1:0]  pal_idx;
  logic              starve;

  assign fmt_e      = pix_fmt_e'(fmt);
  assign req_active = pix_req && (fmt_e != FMT_OFF);
  assign starve     = req_active && !avail;

  pu_word_buf #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .req_active(req_active),
    .slots(slots_of(fmt_e)), .in_valid(word_valid), .in_data(word_data),
    .in_ready(word_ready), .avail(avail), .have_word(have_word),
    .consume(consume), .cur_word(cur_word), .cur_slot(cur_slot)
  );

  pu_fmt_expand u_exp (
    .fmt(fmt_e), .word(cur_word), .slot(cur_slot),
    .direct_rgb(direct_rgb), .pal_idx(pal_idx)
  );

  pu_palette #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_pal (
    .clk(clk), .we(pal_we), .waddr(pal_wdata[31:24]), .wdata(pal_wdata[23:0]),
    .re(consume && (fmt_e == FMT_IDX8)), .raddr(pal_idx), .rdata(pal_rdata)
  );

  logic             valid_q, uflow_q, use_pal_q;
  logic [RGB_W-1:0] direct_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      uflow_q   <= 1'b0;
      use_pal_q <= 1'b0;
      direct_q  <= '0;
    end else begin
      valid_q   <= req_active;
      uflow_q   <= starve;
      use_pal_q <= consume && (fmt_e == FMT_IDX8);
      direct_q  <= consume ? direct_rgb : '0;
    end
  end

  assign pix_valid = valid_q;
  assign underflow = uflow_q;
  assign pix_rgb   = use_pal_q ? pal_rdata : direct_q;
endmodule

// File: rtl/pu_checker.sv
`timescale 1ns/1ps
module pu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  fmt,
  input logic        pix_req,
  input logic        word_valid,
  input logic        word_ready,
  input logic        have_word,
  input logic        pix_valid,
  input logic [23:0] pix_rgb,
  input logic        underflow
);
  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && fmt != 2'd0) |=> pix_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_req && fmt != 2'd0) |=> !pix_valid);
  a_r8_underflow_black: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (pix_valid && pix_rgb == 24'd0));
  a_r8_underflow_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && fmt != 2'd0 && !have_word && !word_valid) |=> underflow);
  a_r9_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> pix_req);
  a_r9_no_ready_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    have_word |-> !word_ready);
  a_r10_off_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd0) |-> !word_ready);
endmodule

bind pix_unpack pu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(fmt), .pix_req(pix_req),
  .word_valid(word_valid), .word_ready(word_ready), .have_word(have_word),
  .pix_valid(pix_valid), .pix_rgb(pix_rgb), .underflow(underflow)
);

// File: tb/tb_pix_unpack.sv
`timescale 1ns/1ps
module tb_pix_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        pal_we = 1'b0;
  logic [31:0] pal_wdata = '0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic        pix_req = 1'b0;
  logic        pix_valid;
  logic [23:0] pix_rgb;
  logic        underflow;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] model_pal [256];

  always #5 clk = ~clk;

  pix_unpack dut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .pal_we(pal_we), .pal_wdata(pal_wdata),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .pix_req(pix_req), .pix_valid(pix_valid), .pix_rgb(pix_rgb), .underflow(underflow)
  );

  // stimulus vectors: {format code, framebuffer word}
  localparam logic [33:0] VEC [10] = '{
    {2'd3, 32'hFF123456}, {2'd3, 32'h00ABCDEF}, {2'd3, 32'hA5000000},
    {2'd2, 32'hF80007E0}, {2'd2, 32'h001FFFFF}, {2'd2, 32'h84101234},
    {2'd1, 32'h00FF7F80}, {2'd1, 32'h01020304}, {2'd1, 32'hC35AA53C},
    {2'd2, 32'h0000F81F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int per_word(input logic [1:0] f);
    return (f == 2'd1) ? 4 : (f == 2'd2) ? 2 : 1;
  endfunction

  function automatic logic [23:0] expect_pix(input logic [1:0] f, input logic [31:0] w, input int s);
    logic [31:0] sh;
    logic [7:0] r, g, b;
    if (f == 2'd1) begin
      sh = w >> (24 - 8*s);
      return model_pal[sh[7:0]];
    end else if (f == 2'd2) begin
      sh = (w >> (16 - 16*s)) & 32'hFFFF;
      r = {3'b0, sh[15:11]}; g = {2'b0, sh[10:5]}; b = {3'b0, sh[4:0]};
      r = (r << 3) | (r >> 2);
      g = (g << 2) | (g >> 4);
      b = (b << 3) | (b >> 2);
      return {r, g, b};
    end
    return w[23:0];
  endfunction

  task automatic pal_write(input logic [7:0] idx, input logic [23:0] rgb);
    pal_we = 1'b1;
    pal_wdata = {idx, rgb};
    @(posedge clk); #2;
    pal_we = 1'b0;
    model_pal[idx] = rgb;
  endtask

  task automatic run_word(input logic [1:0] f, input logic [31:0] w, input string tag);
    fmt = f;
    for (int s = 0; s < per_word(f); s++) begin
      pix_req = 1'b1;
      word_valid = (s == 0);
      word_data = w;
      #1;
      check("R9", {31'd0, word_ready}, {31'd0, (s == 0)});
      @(posedge clk); #2;
      check(tag, {8'd0, pix_rgb}, {8'd0, expect_pix(f, w, s)});
      check("R2", {31'd0, pix_valid}, 32'd1);
    end
    pix_req = 1'b0;
    word_valid = 1'b0;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    #23;
    // R1: reset state
    check("R1", {31'd0, pix_valid}, 32'd0);
    check("R1", {31'd0, underflow}, 32'd0);
    check("R1", {31'd0, word_ready}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R6: load every palette entry with a bench-computed colour
    for (int i = 0; i < 256; i++) pal_write(i[7:0], {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A});

    // table walk: R3 direct, R4 5-6-5, R5 indexed
    for (int v = 0; v < 10; v++) begin
      run_word(VEC[v][33:32], VEC[v][31:0],
               VEC[v][33:32] == 2'd1 ? "R5" : VEC[v][33:32] == 2'd2 ? "R4" : "R3");
      @(posedge clk); #2;
      check("R2", {31'd0, pix_valid}, 32'd0);
    end

    // R8: request with no data
    fmt = 2'd3; pix_req = 1'b1; word_valid = 1'b0;
    @(posedge clk); #2;
    pix_req = 1'b0;
    check("R8", {31'd0, underflow}, 32'd1);
    check("R8", {8'd0, pix_rgb}, 32'd0);
    check("R8", {31'd0, pix_valid}, 32'd1);
    run_word(2'd3, 32'h00135790, "R8");

    // R10: format off ignores requests and words
    fmt = 2'd0; pix_req = 1'b1; word_valid = 1'b1; word_data = 32'h00FFFFFF;
    #1;
    check("R10", {31'd0, word_ready}, 32'd0);
    @(posedge clk); #2;
    pix_req = 1'b0; word_valid = 1'b0;
    check("R10", {31'd0, pix_valid}, 32'd0);
    run_word(2'd2, 32'hFFFF0000, "R10");

    // R7: write and lookup of index 0x33 in the same cycle
    fmt = 2'd1; pix_req = 1'b1; word_valid = 1'b1; word_data = 32'h33330000;
    pal_we = 1'b1; pal_wdata = 32'h33ABCDEF;
    @(posedge clk); #2;
    pal_we = 1'b0; word_valid = 1'b0;
    check("R7", {8'd0, pix_rgb}, {8'd0, model_pal[8'h33]});
    model_pal[8'h33] = 24'hABCDEF;
    @(posedge clk); #2;
    check("R7", {8'd0, pix_rgb}, 32'h00ABCDEF);
    @(posedge clk); #2;
    @(posedge clk); #2;
    pix_req = 1'b0;
    check("R5", {8'd0, pix_rgb}, {8'd0, model_pal[8'h00]});

    report();
  end
endmodule